// File: doc/BRIEF.md
# Register-Cached Memory Stack

This block is a last-in, first-out store whose bulk lives in a single-port RAM. The topmost value is held in one dedicated register, and the block keeps a flag that says whether that register is occupied. Memory is touched only when this cannot be avoided. A push into an empty register costs nothing in memory. A push onto an occupied register first moves the old top into RAM. A pop, add or subtract reads the entry just beneath the register back out of RAM.

Commands arrive on a valid/ready handshake with a 2-bit operation code and a push value. The cached top is always visible on an output. A counter reports how many RAM reads and writes have been made since reset, so that software or a bench can measure the traffic a command sequence causes. Illegal commands set a sticky error flag and leave the stack untouched.

Top module: `tos_stack`

## Requirements
- R1: After reset the register is empty (`tos_full`=0), `err_flag`=0, `access_count`=0 and `cmd_ready`=1.
- R2: A push while the register is empty loads `push_data` into the register. It makes no RAM access and leaves `cmd_ready` high.
- R3: A push while the register is occupied writes the old top into RAM and loads `push_data`, visible after the accepting edge. It raises `access_count` by one and leaves `cmd_ready` high.
- R4: A pop discards the top. If RAM holds entries, the register is refilled from the entry just below, `access_count` rises by one, and `cmd_ready` is low for exactly one cycle. If RAM is empty, the register becomes empty and no access is made.
- R5: Add (code 2'b10) replaces the two topmost values with their sum modulo 2^16, keeps the result in the register, makes one RAM read and drops `cmd_ready` for one cycle.
- R6: Subtract (code 2'b11) replaces the two topmost values with (lower entry − top) modulo 2^16, with the same access and ready behaviour as add.
- R7: The operation codes are push = 2'b00, pop = 2'b01, add = 2'b10 and subtract = 2'b11.
- R8: The RAM holds 64 entries, so the stack holds 65 values in total. A push with 65 values present sets `err_flag` and leaves the top, the depth and `access_count` unchanged.
- R9: A pop with no values, or an add or subtract with fewer than two values, sets `err_flag` and leaves the stack and `access_count` unchanged.
- R10: `err_flag` stays set until reset, whatever commands follow.
- R11: Values come back in the reverse of the order in which they were pushed, over the full depth.
- R12: Starting from empty, push X, push 1, add leaves X+1 in the register after exactly 2 RAM accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| cmd_op | input | 2 | Operation code (R7) |
| push_data | input | 16 | Value for a push |
| tos_data | output | 16 | Cached top value |
| tos_full | output | 1 | Top register holds a value |
| err_flag | output | 1 | Sticky illegal-command flag |
| access_count | output | 16 | RAM reads plus writes since reset |

## Verification
The hardest states to reach from the ports are the two ends of the RAM part: a push that meets exactly 64 spilled entries, and a pop that drains the last RAM entry so the following pop only empties the register. The stimulus pushes 65 patterned values and one extra, then pops all of them and one more, checking each value and the traffic count against a model in the bench. An operand grid and a long pseudo-random command run follow, with illegal commands mixed in.

// File: rtl/tos_stack_pkg.sv
package tos_stack_pkg;
  typedef enum logic [1:0] {
    OP_PUSH = 2'b00,
    OP_POP  = 2'b01,
    OP_ADD  = 2'b10,
    OP_SUB  = 2'b11
  } stk_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } stk_state_e;
endpackage

// File: rtl/stack_ram.sv
module stack_ram #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Single port: a write or a registered read per cycle.
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/access_counter.sv
module access_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (hit) count <= count + 1'b1;
  end

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> count == $past(count) + 1'b1);
  // R9
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(count));
endmodule

// File: rtl/stack_ctrl.sv
module stack_ctrl
  import tos_stack_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [DATA_W-1:0] push_data,
  output logic              cmd_ready,
  output logic [DATA_W-1:0] tos_data,
  output logic              tos_full,
  output logic              err_flag,
  output logic              ram_en,
  output logic              ram_we,
  output logic [AW-1:0]     ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata
);
  localparam logic [AW:0] SP_FULL = (AW+1)'(DEPTH);

  function automatic logic [DATA_W-1:0] combine(stk_op_e op,
                                                logic [DATA_W-1:0] lower,
                                                logic [DATA_W-1:0] top);
    return (op == OP_SUB) ? lower - top : lower + top;
  endfunction

  stk_state_e        state;
  stk_op_e           op, pend_op;
  logic [AW:0]       sp;
  logic [AW:0]       sp_dec;
  logic [DATA_W-1:0] tos_q;
  logic              full_q, err_q;

  // Named events, one per command outcome.
  logic accept, is_arith, ram_has;
  logic push_fill, push_spill, push_ovf;
  logic pop_drop, pop_refill, arith_go, bad_cmd, rd_issue;

  assign op         = stk_op_e'(cmd_op);
  assign sp_dec     = sp - 1'b1;
  assign cmd_ready  = (state == ST_IDLE);
  assign accept     = cmd_valid && cmd_ready;
  assign is_arith   = (op == OP_ADD) || (op == OP_SUB);
  assign ram_has    = (sp != '0);

  assign push_fill  = accept && (op == OP_PUSH) && !full_q;
  assign push_spill = accept && (op == OP_PUSH) && full_q && (sp != SP_FULL);
  assign push_ovf   = accept && (op == OP_PUSH) && full_q && (sp == SP_FULL);
  assign pop_drop   = accept && (op == OP_POP) && full_q && !ram_has;
  assign pop_refill = accept && (op == OP_POP) && full_q && ram_has;
  assign arith_go   = accept && is_arith && full_q && ram_has;
  assign bad_cmd    = accept && (((op == OP_POP) && !full_q) ||
                                 (is_arith && !(full_q && ram_has)));
  assign rd_issue   = pop_refill || arith_go;

  assign ram_en     = push_spill || rd_issue;
  assign ram_we     = push_spill;
  assign ram_addr   = push_spill ? sp[AW-1:0] : sp_dec[AW-1:0];
  assign ram_wdata  = tos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      pend_op <= OP_PUSH;
      sp      <= '0;
      tos_q   <= '0;
      full_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (push_fill) begin
            tos_q  <= push_data;
            full_q <= 1'b1;
          end
          if (push_spill) begin
            tos_q <= push_data;
            sp    <= sp + 1'b1;
          end
          if (pop_drop) full_q <= 1'b0;
          if (rd_issue) begin
            sp      <= sp_dec;
            pend_op <= op;
            state   <= ST_WAIT;
          end
          if (push_ovf || bad_cmd) err_q <= 1'b1;
        end
        default: begin
          tos_q <= (pend_op == OP_POP) ? ram_rdata
                                       : combine(pend_op, ram_rdata, tos_q);
          state <= ST_IDLE;
        end
      endcase
    end
  end

  assign tos_data = tos_q;
  assign tos_full = full_q;
  assign err_flag = err_q;

  // R4
  rd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue |=> !cmd_ready ##1 cmd_ready);
  // R8
  sp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SP_FULL);
  // R2
  fill_no_spill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_fill |=> tos_full && (sp == $past(sp)) && (tos_data == $past(push_data)));
  // R3
  spill_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_spill |=> tos_full && (tos_data == $past(push_data)) && (sp == $past(sp) + 1'b1));
  // R9
  hold_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ovf || bad_cmd) |=> err_flag && $stable(tos_data) && $stable(sp) && $stable(tos_full));
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
endmodule

// File: rtl/tos_stack.sv
module tos_stack #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  parameter int CNT_W  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [DATA_W-1:0] push_data,
  output logic [DATA_W-1:0] tos_data,
  output logic              tos_full,
  output logic              err_flag,
  output logic [CNT_W-1:0]  access_count
);
  logic              ram_en, ram_we;
  logic [AW-1:0]     ram_addr;
  logic [DATA_W-1:0] ram_wdata, ram_rdata;

  stack_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .push_data (push_data),
    .cmd_ready (cmd_ready),
    .tos_data  (tos_data),
    .tos_full  (tos_full),
    .err_flag  (err_flag),
    .ram_en    (ram_en),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .ram_rdata (ram_rdata)
  );

  stack_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .en    (ram_en),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );

  access_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (ram_en),
    .count (access_count)
  );
endmodule

// File: tb/tos_stack_test.sv
`timescale 1ns/1ps
module tos_stack_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'b00;
  logic [15:0] push_data = '0;
  logic [15:0] tos_data;
  logic        tos_full;
  logic        err_flag;
  logic [15:0] access_count;

  always #2 clk = ~clk;

  tos_stack uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .push_data(push_data), .tos_data(tos_data),
    .tos_full(tos_full), .err_flag(err_flag), .access_count(access_count)
  );

  int n_chk = 0, n_fail = 0;
  logic [15:0] mdl [0:127];
  int mn = 0, mcnt = 0;
  bit merr = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cmd_valid = 1'b0;
    mn = 0; mcnt = 0; merr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Applies the model, drives one command, then compares every output.
  task automatic run(input logic [1:0] op, input logic [15:0] d, input string tag);
    bit exp_gap = 0;
    bit got_gap;
    case (op)
      2'b00: begin
        if (mn == 65) merr = 1;
        else begin
          if (mn > 0) mcnt++;
          mdl[mn] = d; mn++;
        end
      end
      2'b01: begin
        if (mn == 0) merr = 1;
        else begin
          if (mn > 1) begin mcnt++; exp_gap = 1; end
          mn--;
        end
      end
      default: begin
        if (mn < 2) merr = 1;
        else begin
          mcnt++; exp_gap = 1;
          mdl[mn-2] = (op == 2'b11) ? mdl[mn-2] - mdl[mn-1] : mdl[mn-2] + mdl[mn-1];
          mn--;
        end
      end
    endcase
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; push_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    got_gap = !cmd_ready;
    while (!cmd_ready) @(negedge clk);
    chk(tag, "ready gap", int'(got_gap), int'(exp_gap));
    chk(tag, "tos_full", int'(tos_full), int'(mn > 0));
    if (mn > 0) chk(tag, "tos_data", int'(tos_data), int'(mdl[mn-1]));
    chk(tag, "access_count", int'(access_count), mcnt & 16'hFFFF);
    chk(tag, "err_flag", int'(err_flag), int'(merr));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  logic [15:0] grid [8] = '{16'h0000, 16'h0001, 16'h0002, 16'h1234,
                            16'h7FFF, 16'h8000, 16'hFFFE, 16'hFFFF};
  logic [23:0] lfsr;

  initial begin
    do_reset();
    // R1 reset state
    chk("R1", "tos_full", int'(tos_full), 0);
    chk("R1", "err_flag", int'(err_flag), 0);
    chk("R1", "access_count", int'(access_count), 0);
    chk("R1", "cmd_ready", int'(cmd_ready), 1);

    // R2 then R12: X, 1, add
    run(2'b00, 16'h1234, "R2");
    run(2'b00, 16'h0001, "R12");
    run(2'b10, 16'h0000, "R12");
    chk("R12", "sum", int'(tos_data), 16'h1235);
    chk("R12", "accesses", int'(access_count), 2);

    // R3 / R8 / R11: fill to 65 values, then overflow
    do_reset();
    for (int i = 0; i < 65; i++) run(2'b00, 16'(i * 37 + 5), "R3");
    chk("R3", "spill count", int'(access_count), 64);
    run(2'b00, 16'hBEEF, "R8");
    chk("R8", "top kept", int'(tos_data), 16'((64 * 37 + 5) & 16'hFFFF));
    for (int i = 64; i >= 0; i--) begin
      chk("R11", "order", int'(tos_data), (i * 37 + 5) & 16'hFFFF);
      run(2'b01, 16'h0000, "R4");
    end
    run(2'b01, 16'h0000, "R9");
    run(2'b10, 16'h0000, "R9");
    run(2'b00, 16'h0042, "R9");
    run(2'b11, 16'h0000, "R9");
    run(2'b00, 16'h0007, "R10");
    chk("R10", "sticky", int'(err_flag), 1);

    // R5 / R6 operand grid
    do_reset();
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++) begin
        run(2'b00, grid[a], "R5");
        run(2'b00, grid[b], "R5");
        run(2'b10, 16'h0000, "R5");
        run(2'b00, grid[b], "R6");
        run(2'b11, 16'h0000, "R6");
        run(2'b01, 16'h0000, "R6");
      end

    // R7 pseudo-random command mix
    do_reset();
    lfsr = 24'hACE1;
    for (int k = 0; k < 1500; k++) begin
      logic [1:0] op;
      lfsr = {lfsr[22:0], lfsr[23] ^ lfsr[22] ^ lfsr[21] ^ lfsr[16]};
      op = (lfsr[3:2] == 2'b00 || lfsr[3:2] == 2'b01) ? 2'b00 : lfsr[1:0];
      if (k > 900 && lfsr[4]) op = 2'b01;
      run(op, lfsr[19:4], "R7");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule